// File: doc/BRIEF.md
# Bytecode-to-Microcode Translation Stage

This block is the front end of a stack processor. It accepts a stream of 8-bit bytecodes over a valid/ready handshake. Each accepted bytecode is looked up in a 256-entry jump table, which gives the first address of its microcode sequence. A micro program counter then walks that sequence one fixed-length, single-cycle micro-op per clock. When the running micro-op carries a `next` flag, the stage takes the following bytecode in that same cycle, so consecutive bytecodes overlap without a bubble.

Simple bytecodes map onto exactly one micro-op. Stack shuffles such as duplicate-below-top and swap run as short sequences that park values in two scratch registers. Bytecodes that have no microcode all jump to one shared entry. That entry raises a one-cycle request, carrying the bytecode, for a software handler. A small operand stack is built in so that the effect of every sequence can be seen at the ports.

Top module: `bcx_stage`

## Requirements
- R1: After a synchronous reset the stage is idle: `bc_ready` is 1, `depth_o` is 0 and `trap_o` is 0.
- R2: Bytecodes 0x00 (no-op), 0x03..0x08 (push constant 0..5), 0x57 (drop top), 0x59 (duplicate top), 0x60 (add) and 0x64 (subtract, below minus top) each take one cycle. The next bytecode offered is accepted exactly one cycle after them.
- R3: Bytecode 0x5A turns a stack ending in x,y (y on top) into y,x,y. It takes exactly five cycles before the next bytecode is accepted.
- R4: Bytecode 0x5F exchanges the two top entries and takes exactly four cycles.
- R5: Any other bytecode leaves the stack unchanged and takes one cycle. Exactly one cycle of `trap_o` follows, with `trap_code` equal to that bytecode.
- R6: While a multi-op sequence has not reached its last micro-op, `bc_ready` is 0. A bytecode held on the input meanwhile is consumed exactly once.
- R7: Arithmetic wraps modulo 2^DATA_W.
- R8: When no bytecode is offered, the stack contents and depth hold and `bc_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bc_valid | input | 1 | A bytecode is offered |
| bc_data | input | 8 | Offered bytecode |
| bc_ready | output | 1 | Stage takes the offered bytecode this cycle |
| trap_o | output | 1 | One-cycle software-handler request |
| trap_code | output | 8 | Bytecode that caused the request |
| tos_o | output | DATA_W | Top of operand stack |
| nos_o | output | DATA_W | Entry below top (0 when depth < 2) |
| depth_o | output | $clog2(STACK_DEPTH+1) | Number of stack entries |

## Verification
The hardest case to reach is a bytecode that arrives while a five- or four-op sequence is in flight and is then taken in the very cycle of the final micro-op. If the overlap is off by one, the spacing changes. If a stalled bytecode is consumed twice, the depth changes. To reach it, the stimulus keeps `bc_valid` high back to back through long random chains. The picks are constrained by a bench model of the stack depth so that every shuffle and arithmetic op is legal. The bench measures the stall cycles before each acceptance against the micro-op count of the previous bytecode. Unlisted bytecodes are mixed in, so that traps also land inside chains.

// File: rtl/bcx_pkg.sv
package bcx_pkg;
  typedef enum logic [3:0] {
    UOP_NOP, UOP_LDI, UOP_DUP, UOP_POP, UOP_ADD, UOP_SUB,
    UOP_STA, UOP_STB, UOP_LDA, UOP_LDB, UOP_TRAP
  } uop_e;

  typedef struct packed {
    uop_e       op;
    logic       nxt;
    logic [7:0] imm;
  } uop_t;

  // microcode entry addresses
  localparam int A_NOP  = 0;
  localparam int A_TRAP = 1;
  localparam int A_DUP  = 2;
  localparam int A_POP  = 3;
  localparam int A_ADD  = 4;
  localparam int A_SUB  = 5;
  localparam int A_LDI  = 6;   // six entries, constants 0..5
  localparam int A_DX1  = 12;  // five entries
  localparam int A_SWP  = 17;  // four entries
  localparam int A_LAST = 20;

  // bytecode values
  localparam logic [7:0] BC_NOP  = 8'h00;
  localparam logic [7:0] BC_C0   = 8'h03;
  localparam logic [7:0] BC_C5   = 8'h08;
  localparam logic [7:0] BC_POP  = 8'h57;
  localparam logic [7:0] BC_DUP  = 8'h59;
  localparam logic [7:0] BC_DX1  = 8'h5A;
  localparam logic [7:0] BC_SWP  = 8'h5F;
  localparam logic [7:0] BC_ADD  = 8'h60;
  localparam logic [7:0] BC_SUB  = 8'h64;
endpackage

// File: rtl/bcx_jtab.sv
module bcx_jtab
  import bcx_pkg::*;
#(
  parameter int UADDR_W = 5
) (
  input  logic [7:0]         bc,
  output logic [UADDR_W-1:0] entry
);
  always_comb begin
    entry = UADDR_W'(A_TRAP);
    if (bc >= BC_C0 && bc <= BC_C5) begin
      entry = UADDR_W'(A_LDI + int'(bc) - int'(BC_C0));
    end else begin
      case (bc)
        BC_NOP: entry = UADDR_W'(A_NOP);
        BC_POP: entry = UADDR_W'(A_POP);
        BC_DUP: entry = UADDR_W'(A_DUP);
        BC_DX1: entry = UADDR_W'(A_DX1);
        BC_SWP: entry = UADDR_W'(A_SWP);
        BC_ADD: entry = UADDR_W'(A_ADD);
        BC_SUB: entry = UADDR_W'(A_SUB);
        default: entry = UADDR_W'(A_TRAP);
      endcase
    end
  end
endmodule

// File: rtl/bcx_urom.sv
module bcx_urom
  import bcx_pkg::*;
#(
  parameter int UADDR_W = 5
) (
  input  logic [UADDR_W-1:0] addr,
  output uop_t               uop
);
  int a;
  always_comb begin
    a   = int'(addr);
    uop = '{op: UOP_NOP, nxt: 1'b1, imm: 8'h00};
    if (a >= A_LDI && a < A_LDI + 6) begin
      uop = '{op: UOP_LDI, nxt: 1'b1, imm: 8'(a - A_LDI)};
    end else begin
      case (a)
        A_NOP:     uop = '{op: UOP_NOP,  nxt: 1'b1, imm: 8'h00};
        A_TRAP:    uop = '{op: UOP_TRAP, nxt: 1'b1, imm: 8'h00};
        A_DUP:     uop = '{op: UOP_DUP,  nxt: 1'b1, imm: 8'h00};
        A_POP:     uop = '{op: UOP_POP,  nxt: 1'b1, imm: 8'h00};
        A_ADD:     uop = '{op: UOP_ADD,  nxt: 1'b1, imm: 8'h00};
        A_SUB:     uop = '{op: UOP_SUB,  nxt: 1'b1, imm: 8'h00};
        // duplicate below top: park both, rebuild three
        A_DX1:     uop = '{op: UOP_STA,  nxt: 1'b0, imm: 8'h00};
        A_DX1 + 1: uop = '{op: UOP_STB,  nxt: 1'b0, imm: 8'h00};
        A_DX1 + 2: uop = '{op: UOP_LDA,  nxt: 1'b0, imm: 8'h00};
        A_DX1 + 3: uop = '{op: UOP_LDB,  nxt: 1'b0, imm: 8'h00};
        A_DX1 + 4: uop = '{op: UOP_LDA,  nxt: 1'b1, imm: 8'h00};
        // exchange: park both, reload crossed
        A_SWP:     uop = '{op: UOP_STA,  nxt: 1'b0, imm: 8'h00};
        A_SWP + 1: uop = '{op: UOP_STB,  nxt: 1'b0, imm: 8'h00};
        A_SWP + 2: uop = '{op: UOP_LDA,  nxt: 1'b0, imm: 8'h00};
        A_SWP + 3: uop = '{op: UOP_LDB,  nxt: 1'b1, imm: 8'h00};
        default:   uop = '{op: UOP_NOP,  nxt: 1'b1, imm: 8'h00};
      endcase
    end
  end
endmodule

// File: rtl/bcx_stack.sv
module bcx_stack
  import bcx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  uop_e                         op,
  input  logic [DATA_W-1:0]            imm,
  output logic [DATA_W-1:0]            tos,
  output logic [DATA_W-1:0]            nos,
  output logic [$clog2(DEPTH+1)-1:0]   depth
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] tos_q, sa_q, sb_q, push_v, below, bin_v;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  widx, ridx;
  logic              is_push, is_pop, is_bin, can_push, has2;

  always_comb begin
    is_push = 1'b0;
    is_pop  = 1'b0;
    is_bin  = 1'b0;
    push_v  = imm;
    case (op)
      UOP_LDI: is_push = 1'b1;
      UOP_DUP: begin is_push = 1'b1; push_v = tos_q; end
      UOP_LDA: begin is_push = 1'b1; push_v = sa_q;  end
      UOP_LDB: begin is_push = 1'b1; push_v = sb_q;  end
      UOP_POP, UOP_STA, UOP_STB: is_pop = 1'b1;
      UOP_ADD, UOP_SUB: is_bin = 1'b1;
      default: ;
    endcase
  end

  assign can_push = cnt_q != CNT_W'(DEPTH);
  assign has2     = cnt_q >= CNT_W'(2);
  assign widx     = IDX_W'(cnt_q - CNT_W'(1));
  assign ridx     = IDX_W'(cnt_q - CNT_W'(2));
  assign below    = mem[ridx];
  assign bin_v    = (op == UOP_ADD) ? below + tos_q : below - tos_q;

  // spill array: write-only port, no reset
  always_ff @(posedge clk) begin
    if (is_push && can_push && cnt_q != '0) mem[widx] <= tos_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tos_q <= '0;
      sa_q  <= '0;
      sb_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (is_push && can_push) begin
        tos_q <= push_v;
        cnt_q <= cnt_q + CNT_W'(1);
      end else if (is_pop && cnt_q != '0) begin
        if (op == UOP_STA) sa_q <= tos_q;
        if (op == UOP_STB) sb_q <= tos_q;
        tos_q <= has2 ? below : '0;
        cnt_q <= cnt_q - CNT_W'(1);
      end else if (is_bin && has2) begin
        tos_q <= bin_v;
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign tos   = tos_q;
  assign nos   = has2 ? below : '0;
  assign depth = cnt_q;

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
    (is_push && can_push) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (op == UOP_NOP) |=> ($stable(cnt_q) && $stable(tos_q))); // R8
endmodule

// File: rtl/bcx_stage.sv
module bcx_stage
  import bcx_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int STACK_DEPTH = 16,
  parameter int UADDR_W     = 5
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               bc_valid,
  input  logic [7:0]                         bc_data,
  output logic                               bc_ready,
  output logic                               trap_o,
  output logic [7:0]                         trap_code,
  output logic [DATA_W-1:0]                  tos_o,
  output logic [DATA_W-1:0]                  nos_o,
  output logic [$clog2(STACK_DEPTH+1)-1:0]   depth_o
);
  logic [UADDR_W-1:0] upc_q, entry;
  logic [7:0]         bc_q;
  logic               run_q, accept, trap_q;
  uop_t               cur;
  uop_e               stk_op;

  bcx_jtab #(.UADDR_W(UADDR_W)) u_jtab (.bc(bc_data), .entry(entry));
  bcx_urom #(.UADDR_W(UADDR_W)) u_urom (.addr(upc_q), .uop(cur));

  assign bc_ready = !run_q || cur.nxt;
  assign accept   = bc_valid && bc_ready;
  assign stk_op   = run_q ? cur.op : UOP_NOP;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      upc_q     <= '0;
      bc_q      <= '0;
      trap_q    <= 1'b0;
      trap_code <= '0;
    end else begin
      trap_q <= run_q && (cur.op == UOP_TRAP);
      if (run_q && cur.op == UOP_TRAP) trap_code <= bc_q;
      if (accept) begin
        upc_q <= entry;
        bc_q  <= bc_data;
        run_q <= 1'b1;
      end else if (run_q && cur.nxt) begin
        run_q <= 1'b0;
      end else if (run_q) begin
        upc_q <= upc_q + UADDR_W'(1);
      end
    end
  end

  assign trap_o = trap_q;

  bcx_stack #(.DATA_W(DATA_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst(rst), .op(stk_op), .imm(DATA_W'(cur.imm)),
    .tos(tos_o), .nos(nos_o), .depth(depth_o)
  );

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> bc_ready); // R8
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (run_q && !cur.nxt) |=> (run_q && upc_q == $past(upc_q) + UADDR_W'(1))); // R6
  AST_ACCEPT_RUNS: assert property (@(posedge clk) disable iff (rst)
    accept |=> run_q); // R6
  AST_TRAP_SRC: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> $past(run_q && cur.op == UOP_TRAP)); // R5
endmodule

// File: tb/bcx_stage_bench.sv
module bcx_stage_bench;
  localparam int DW = 16;
  localparam int SD = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bc_valid = 1'b0;
  logic [7:0]    bc_data = 8'h00;
  logic          bc_ready, trap_o;
  logic [7:0]    trap_code;
  logic [DW-1:0] tos_o, nos_o;
  logic [4:0]    depth_o;

  bcx_stage #(.DATA_W(DW), .STACK_DEPTH(SD), .UADDR_W(5)) u_bcx_stage (
    .clk(clk), .rst(rst), .bc_valid(bc_valid), .bc_data(bc_data),
    .bc_ready(bc_ready), .trap_o(trap_o), .trap_code(trap_code),
    .tos_o(tos_o), .nos_o(nos_o), .depth_o(depth_o)
  );

  always #2 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  int traps_seen = 0, traps_exp = 0;
  logic [7:0] trap_last = 8'h00;
  logic [DW-1:0] stk [0:31];
  int mcnt = 0;
  int prev_len = 1;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d cycles exp<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(negedge clk) if (!rst && trap_o) begin
    traps_seen++; trap_last = trap_code;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int len_of(input logic [7:0] b);
    if (b == 8'h5A) return 5;
    if (b == 8'h5F) return 4;
    return 1;
  endfunction

  function automatic bit known(input logic [7:0] b);
    return (b == 8'h00) || (b >= 8'h03 && b <= 8'h08) || b == 8'h57 ||
           b == 8'h59 || b == 8'h5A || b == 8'h5F || b == 8'h60 || b == 8'h64;
  endfunction

  task automatic model(input logic [7:0] b);
    logic [DW-1:0] x, y;
    if (b >= 8'h03 && b <= 8'h08) begin stk[mcnt] = DW'(b - 8'h03); mcnt++; end
    else case (b)
      8'h57: mcnt--;
      8'h59: begin stk[mcnt] = stk[mcnt-1]; mcnt++; end
      8'h60: begin stk[mcnt-2] = stk[mcnt-2] + stk[mcnt-1]; mcnt--; end
      8'h64: begin stk[mcnt-2] = stk[mcnt-2] - stk[mcnt-1]; mcnt--; end
      8'h5F: begin x = stk[mcnt-2]; stk[mcnt-2] = stk[mcnt-1]; stk[mcnt-1] = x; end
      8'h5A: begin
        x = stk[mcnt-2]; y = stk[mcnt-1];
        stk[mcnt-2] = y; stk[mcnt-1] = x; stk[mcnt] = y; mcnt++;
      end
      default: if (!known(b)) traps_exp++;
    endcase
  endtask

  // offer b at a negedge; chained = offered right after previous acceptance
  task automatic send(input logic [7:0] b, input bit chained, input string tag);
    int waits = 0;
    bc_valid = 1'b1; bc_data = b;
    while (!bc_ready) begin @(negedge clk); waits++; end
    chk(waits == (chained ? prev_len - 1 : 0), tag, waits + 1,
        chained ? prev_len : 1);
    @(posedge clk); @(negedge clk);
    bc_valid = 1'b0;
    model(b);
    prev_len = len_of(b);
  endtask

  task automatic idle(input int n);
    bc_valid = 1'b0;
    repeat (n) @(negedge clk);
    prev_len = 1;
  endtask

  task automatic check_stack(input string tag);
    chk(int'(depth_o) == mcnt, {tag, " depth"}, depth_o, mcnt);
    if (mcnt > 0) chk(tos_o == stk[mcnt-1], {tag, " tos"}, tos_o, stk[mcnt-1]);
    if (mcnt > 1) chk(nos_o == stk[mcnt-2], {tag, " nos"}, nos_o, stk[mcnt-2]);
  endtask

  function automatic logic [7:0] pick();
    logic [7:0] c;
    for (int t = 0; t < 100; t++) begin
      case ($urandom % 11)
        0: c = 8'h00;
        1, 2: c = 8'(8'h03 + $urandom % 6);
        3: c = 8'h57;
        4: c = 8'h59;
        5: c = 8'h5A;
        6: c = 8'h5F;
        7: c = 8'h60;
        8: c = 8'h64;
        9: c = 8'hB6;
        default: c = 8'hC3;
      endcase
      if ((c >= 8'h03 && c <= 8'h08) && mcnt < SD) return c;
      if (c == 8'h59 && mcnt >= 1 && mcnt < SD) return c;
      if (c == 8'h57 && mcnt >= 1) return c;
      if (c == 8'h5A && mcnt >= 2 && mcnt < SD) return c;
      if ((c == 8'h5F || c == 8'h60 || c == 8'h64) && mcnt >= 2) return c;
      if (c == 8'h00 || c == 8'hB6 || c == 8'hC3) return c;
    end
    return 8'h00;
  endfunction

  initial begin
    void'($urandom(32'h1A2B3C));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(bc_ready == 1'b1, "R1 ready", bc_ready, 1);
    chk(depth_o == 0, "R1 depth", depth_o, 0);
    chk(trap_o == 1'b0, "R1 trap", trap_o, 0);

    // R2 / R7: single-cycle ops, wrap on subtract
    send(8'h06, 0, "R2 spacing");
    send(8'h08, 1, "R2 spacing");
    send(8'h64, 1, "R2 spacing");
    idle(4);
    chk(tos_o == 16'hFFFE, "R7 wrap sub", tos_o, 16'hFFFE);
    check_stack("R7");
    send(8'h04, 0, "R2 spacing");
    send(8'h60, 1, "R2 spacing");
    idle(4);
    chk(tos_o == 16'hFFFF, "R7 wrap add", tos_o, 16'hFFFF);
    send(8'h57, 0, "R2 spacing");
    idle(4);
    check_stack("R2 pop");

    // R3 duplicate below top, then R6 stall with a held bytecode
    send(8'h04, 0, "R2 spacing");
    send(8'h05, 1, "R2 spacing");
    send(8'h5A, 1, "R2 spacing");
    chk(bc_ready == 1'b0, "R6 stall", bc_ready, 0);
    send(8'h00, 1, "R3 five cycles");
    idle(6);
    check_stack("R3 result");
    chk(tos_o == 16'd2 && nos_o == 16'd1, "R3 order", {tos_o, nos_o}, 32'h0002_0001);
    send(8'h57, 0, "R2 spacing"); send(8'h57, 1, "R2 spacing");
    idle(4);
    chk(tos_o == 16'd2, "R3 deepest", tos_o, 2);
    check_stack("R6 once");

    // R4 swap
    send(8'h08, 0, "R2 spacing");
    send(8'h5F, 1, "R2 spacing");
    send(8'h59, 1, "R4 four cycles");
    idle(6);
    check_stack("R4 result");

    // R5 trap
    begin
      int t0 = traps_seen;
      send(8'hB6, 0, "R2 spacing");
      send(8'h00, 1, "R5 one cycle");
      idle(4);
      chk(traps_seen == t0 + 1, "R5 pulse count", traps_seen, t0 + 1);
      chk(trap_last == 8'hB6, "R5 code", trap_last, 8'hB6);
      check_stack("R5 stack");
    end

    // R8 idle hold
    begin
      logic [DW-1:0] t;
      int d;
      t = tos_o; d = depth_o;
      idle(12);
      chk(tos_o == t && int'(depth_o) == d, "R8 hold", tos_o, t);
      chk(bc_ready == 1'b1, "R8 ready", bc_ready, 1);
    end

    // random chained bursts
    for (int burst = 0; burst < 40; burst++) begin
      for (int k = 0; k < 20; k++) send(pick(), k != 0, "R6 chained spacing");
      idle(7);
      check_stack("R6 random");
    end
    chk(traps_seen == traps_exp, "R5 trap total", traps_seen, traps_exp);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule